// File: doc/BRIEF.md
# Two-level prioritized interrupt controller

The controller watches 31 interrupt request lines (numbered 1 to 31; line 0 does not exist) and keeps four software-visible registers for them: pending, force, mask and level. On every clock it drives a 4-bit request level to a processor. Lines 1 to 15 are ordinary interrupts. Lines 16 to 31 are extended interrupts that share interrupt 1 as their common entry.

Each ordinary interrupt is given one of two priority levels by software. The processor sees the highest-numbered unmasked active interrupt from level 1, or from level 0 when level 1 has none. When the processor services a request it signals an acknowledge with the level it took. The controller then clears the matching pending and force bits. An acknowledge of interrupt 1 also retires one extended source and stores that source's ID, so the handler can find out which extended source it is serving.

Top module: `irqc_top`

## Requirements
- R1: A high level on `irq_i[k]` (k = 1..31) in a cycle sets pending bit k at the next clock edge. Bit 0 of every register reads 0, and `irq_i[0]` has no effect.
- R2: A pending bit stays set until software clears it or the processor acknowledges that interrupt.
- R3: Writing address 1 (pending-clear) with bit k = 1 clears pending bit k. If a request on line k arrives in the same cycle, the bit stays set.
- R4: Writing address 0 (pending-set) with bit k = 1 sets pending bit k. Reading address 0 or address 1 returns the pending register.
- R5: The force register (address 2, read/write) is ORed with pending. A forced bit takes part in prioritization exactly like a pending bit.
- R6: Prioritization uses only bits that are set in the mask register (address 3, read/write; reset value 0). A masked bit still reads back as pending.
- R7: The level register (address 4, bits 15:1, read/write) puts interrupt k on level 1 when bit k is 1. Any active level-1 interrupt wins over every level-0 interrupt, whatever its number.
- R8: Within one level, the higher interrupt number wins.
- R9: Any unmasked pending or forced extended bit (16..31) makes interrupt 1 active. Extended bits have no level and no ordering of their own.
- R10: `irl_o` is 0 when no interrupt is active. It reflects a change of pending, force, mask or level one clock after the register changes.
- R11: An acknowledge (`ack_i` = 1 with `ack_lvl_i` = L, 1..15) clears pending bit L and force bit L.
- R12: An acknowledge of level 1 also clears the lowest-numbered unmasked active extended bit. It writes that bit's ID (16..31) into the extended-acknowledge register (address 5, bits 4:0, reset 0, read-only), which then holds its value until the next such acknowledge.
- R13: A read of any unused address (6, 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 32 | Interrupt request lines, bit 0 unused |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_lvl_i | input | 4 | Level being acknowledged |
| irl_o | output | 4 | Interrupt request level to the processor |

## Verification
The acknowledge-clear assertion relies on two conditions in the acknowledge cycle: no register write is issued, and the acknowledged line does not request again. Without them, an acknowledge could be outweighed by a new request on the same line. The hold assertion likewise covers only cycles with no write and no acknowledge. The stimulus therefore issues register writes, acknowledges and request pulses in separate cycles. The one exception is the deliberate same-cycle request-versus-clear case, and that case involves no acknowledge. Request lines are pulsed for one cycle, so the stored pending bits carry all the persistent state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC_DEF  = 32;
  localparam int NNORM_DEF = 16;
  localparam int AW        = 3;

  typedef enum logic [AW-1:0] {
    ADR_PEND   = 3'd0,
    ADR_PCLR   = 3'd1,
    ADR_FORCE  = 3'd2,
    ADR_MASK   = 3'd3,
    ADR_LEVEL  = 3'd4,
    ADR_EXTACK = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/irqc_ext_pick.sv
module irqc_ext_pick #(
  parameter int NSRC  = 32,
  parameter int NNORM = 16,
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand_i,
  output logic            found_o,
  output logic [IDW-1:0]  id_o
);
  // downward scan so the lowest set extended bit is the one left
  always_comb begin
    found_o = 1'b0;
    id_o    = '0;
    for (int i = NSRC - 1; i >= NNORM; i--) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        id_o    = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NNORM = 16,
  localparam int LW   = $clog2(NNORM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NNORM-1:0] act_i,
  input  logic [NNORM-1:0] lvl_i,
  output logic [LW-1:0]    irl_o
);
  localparam logic [NNORM-1:0] NO_BIT0 = ~NNORM'(1);

  logic [1:0]    any;
  logic [LW-1:0] hi [2];

  for (genvar g = 0; g < 2; g++) begin : g_lvl
    logic [NNORM-1:0] sel;
    assign sel = act_i & ((g == 1) ? lvl_i : ~lvl_i) & NO_BIT0;
    always_comb begin
      any[g] = 1'b0;
      hi[g]  = '0;
      for (int i = 1; i < NNORM; i++) begin
        if (sel[i]) begin
          any[g] = 1'b1;
          hi[g]  = LW'(i);
        end
      end
    end
  end

  logic [LW-1:0] irl_d;
  assign irl_d = any[1] ? hi[1] : (any[0] ? hi[0] : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irl_o <= '0;
    else         irl_o <= irl_d;
  end

  // R10
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(act_i & NO_BIT0)) |=> (irl_o == '0));

  // R7
  lvl1_present_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(act_i & lvl_i & NO_BIT0)) |=> (irl_o != '0));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NNORM = 16,
  localparam int LW   = $clog2(NNORM),
  localparam int IDW  = $clog2(NSRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSRC-1:0]  irq_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [NSRC-1:0]  wdata_i,
  input  logic             ack_i,
  input  logic [LW-1:0]    ack_lvl_i,
  output logic [NSRC-1:0]  eff_o,
  output logic [NNORM-1:0] lvl_o,
  output logic [NSRC-1:0]  rdata_o
);
  localparam logic [NSRC-1:0]  VALID   = ~NSRC'(1);
  localparam logic [NNORM-1:0] VALID_N = ~NNORM'(1);
  localparam logic [NSRC-1:0]  EXT_SEL = {{(NSRC-NNORM){1'b1}}, {NNORM{1'b0}}};

  logic [NSRC-1:0]  pend_q, force_q, mask_q;
  logic [NNORM-1:0] lvl_q;
  logic [IDW-1:0]   extack_q;

  logic [NSRC-1:0] cand, ack_vec, wr_set, wr_clr;
  logic            ext_found;
  logic [IDW-1:0]  ext_id;
  logic            ack_one;

  assign eff_o = (pend_q | force_q) & mask_q;
  assign lvl_o = lvl_q;
  assign cand  = eff_o & EXT_SEL;

  irqc_ext_pick #(.NSRC(NSRC), .NNORM(NNORM)) u_pick (
    .cand_i (cand),
    .found_o(ext_found),
    .id_o   (ext_id)
  );

  assign ack_one = ack_i && (ack_lvl_i == LW'(1));

  always_comb begin
    ack_vec = '0;
    if (ack_i) begin
      for (int i = 1; i < NNORM; i++) begin
        if (ack_lvl_i == LW'(i)) ack_vec[i] = 1'b1;
      end
    end
    if (ack_one && ext_found) ack_vec[ext_id] = 1'b1;
  end

  assign wr_set = (wr_i && addr_i == ADR_PEND) ? wdata_i : '0;
  assign wr_clr = (wr_i && addr_i == ADR_PCLR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      force_q  <= '0;
      mask_q   <= '0;
      lvl_q    <= '0;
      extack_q <= '0;
    end else begin
      // new request or software set beats clear and acknowledge
      pend_q <= ((pend_q & ~wr_clr & ~ack_vec) | wr_set | irq_i) & VALID;
      if (wr_i && addr_i == ADR_FORCE) force_q <= wdata_i & VALID;
      else                             force_q <= force_q & ~ack_vec;
      if (wr_i && addr_i == ADR_MASK)  mask_q  <= wdata_i & VALID;
      if (wr_i && addr_i == ADR_LEVEL) lvl_q   <= wdata_i[NNORM-1:0] & VALID_N;
      if (ack_one && ext_found)        extack_q <= ext_id;
    end
  end

  always_comb begin
    case (addr_i)
      ADR_PEND, ADR_PCLR: rdata_o = pend_q;
      ADR_FORCE:          rdata_o = force_q;
      ADR_MASK:           rdata_o = mask_q;
      ADR_LEVEL:          rdata_o = {{(NSRC-NNORM){1'b0}}, lvl_q};
      ADR_EXTACK:         rdata_o = {{(NSRC-IDW){1'b0}}, extack_q};
      default:            rdata_o = '0;
    endcase
  end

  // R1
  req_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_i & VALID)) |=> ((pend_q & $past(irq_i & VALID)) == $past(irq_i & VALID)));

  // R2
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !ack_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R11
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && ack_lvl_i != '0 && !wr_i && !irq_i[ack_lvl_i])
      |=> (!pend_q[$past(ack_lvl_i)] && !force_q[$past(ack_lvl_i)]));

  // R12
  extack_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_one && ext_found) |=> (extack_q >= IDW'(NNORM)));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NSRC  = NSRC_DEF,
  parameter int NNORM = NNORM_DEF,
  localparam int LW   = $clog2(NNORM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            reg_wr_i,
  input  logic [AW-1:0]   reg_addr_i,
  input  logic [NSRC-1:0] reg_wdata_i,
  output logic [NSRC-1:0] reg_rdata_o,
  input  logic            ack_i,
  input  logic [LW-1:0]   ack_lvl_i,
  output logic [LW-1:0]   irl_o
);
  logic [NSRC-1:0]  eff;
  logic [NNORM-1:0] lvl;
  logic [NNORM-1:0] act;

  irqc_regs #(.NSRC(NSRC), .NNORM(NNORM)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_i    (irq_i),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .ack_i    (ack_i),
    .ack_lvl_i(ack_lvl_i),
    .eff_o    (eff),
    .lvl_o    (lvl),
    .rdata_o  (reg_rdata_o)
  );

  // extended group folds onto interrupt 1
  always_comb begin
    act    = eff[NNORM-1:0];
    act[1] = eff[1] | (|eff[NSRC-1:NNORM]);
  end

  irqc_prio #(.NNORM(NNORM)) u_prio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .lvl_i (lvl),
    .irl_o (irl_o)
  );
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        ack_i = 1'b0;
  logic [3:0]  ack_lvl_i = '0;
  logic [3:0]  irl_o;

  irqc_top dut (.*);

  always #10 clk_i = ~clk_i;

  typedef struct {
    bit          is_irl;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(negedge clk_i) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irl ? {28'd0, irl_o} : reg_rdata_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(); reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(); reg_wr_i = 1'b0;
    step();
  endtask

  task automatic pulse(input logic [31:0] v);
    step(); irq_i = v;
    step(); irq_i = '0;
    step();
  endtask

  task automatic ack(input logic [3:0] l);
    step(); ack_i = 1'b1; ack_lvl_i = l;
    step(); ack_i = 1'b0;
    step();
  endtask

  task automatic exp_irl(input logic [3:0] e, input string tag);
    item_t it;
    it.is_irl = 1'b1; it.exp = {28'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic exp_rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr_i = a;
    it.is_irl = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    step();
    exp_irl(4'd0, "R10 reset irl");
    exp_rd(3'd0, 32'h0, "R4 reset pending");
    exp_rd(3'd5, 32'h0, "R12 reset extack");

    pulse(32'h0000_0021);
    exp_rd(3'd0, 32'h0000_0020, "R1 request sets bit, bit0 ignored");
    exp_irl(4'd0, "R6 all masked");

    wr(3'd3, 32'hFFFF_FFFF);
    exp_rd(3'd3, 32'hFFFF_FFFE, "R1 mask bit0 reads 0");
    exp_irl(4'd5, "R6 unmasked pending shows");

    pulse(32'h0000_0200);
    exp_irl(4'd9, "R8 higher number wins");

    wr(3'd4, 32'h0000_0020);
    exp_irl(4'd5, "R7 level1 beats level0");

    step(); irq_i = 32'h20; reg_wr_i = 1'b1; reg_addr_i = 3'd1; reg_wdata_i = 32'h20;
    step(); irq_i = '0; reg_wr_i = 1'b0;
    step();
    exp_rd(3'd1, 32'h0000_0220, "R3 request beats clear");

    wr(3'd1, 32'h0000_0020);
    exp_rd(3'd0, 32'h0000_0200, "R3 clear");
    exp_irl(4'd9, "R2 remaining pending held");

    wr(3'd0, 32'h0000_0008);
    exp_rd(3'd0, 32'h0000_0208, "R4 software set");

    wr(3'd2, 32'h0000_4000);
    exp_rd(3'd2, 32'h0000_4000, "R5 force readback");
    exp_irl(4'd14, "R5 forced interrupt");

    ack(4'd14);
    exp_rd(3'd2, 32'h0, "R11 ack clears force");
    exp_irl(4'd9, "R11 after ack 14");

    ack(4'd9);
    exp_rd(3'd0, 32'h0000_0008, "R11 ack clears pending");
    exp_irl(4'd3, "R11 after ack 9");

    wr(3'd3, 32'hFFFF_FFF6);
    exp_irl(4'd0, "R6 masked to idle");
    exp_rd(3'd0, 32'h0000_0008, "R6 masked still pending");

    pulse(32'h0012_0000);
    exp_irl(4'd1, "R9 extended onto 1");

    ack(4'd1);
    exp_rd(3'd5, 32'd17, "R12 lowest extended id");
    exp_rd(3'd0, 32'h0010_0008, "R12 lowest extended cleared");
    exp_irl(4'd1, "R9 remaining extended");

    ack(4'd1);
    exp_rd(3'd5, 32'd20, "R12 second extended id");
    exp_irl(4'd0, "R12 extended drained");

    wr(3'd3, 32'hFDFF_FFF6);
    pulse(32'h4200_0000);
    ack(4'd1);
    exp_rd(3'd5, 32'd30, "R12 masked extended skipped");
    exp_rd(3'd0, 32'h0200_0008, "R12 masked extended stays");
    exp_irl(4'd0, "R10 nothing unmasked");

    ack(4'd1);
    exp_rd(3'd5, 32'd30, "R12 extack held without extended");

    exp_rd(3'd7, 32'h0, "R13 unused address");
    exp_rd(3'd6, 32'h0, "R13 unused address 6");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule